// File: doc/BRIEF.md
# Potentiometer Wiper Register and Bank Executor

This block carries out already-decoded commands for a 256-position digital potentiometer. It keeps an 8-bit volatile wiper register, whose value is the selected tap, and sixteen 8-bit storage registers. The storage registers are arranged as four banks of four entries and are treated as nonvolatile: they have no reset and keep their contents across `rst_n`. A command is a 4-bit opcode together with a register index, a bank index and a data byte, presented for one cycle on `cmd_valid`. The block reads and writes the wiper, reads and writes any storage entry, moves values between bank 0 and the wiper, and moves the wiper one tap at a time while step mode is active.

A store into a storage entry models a slow nonvolatile write. The block stays busy for exactly `WR_CYCLES` clock cycles and commits the byte when that count ends. Any command that arrives while the block is busy is dropped. A low `wp_n` blocks stores but leaves every wiper operation working. After each reset release, a recall state copies bank 0 entry 0 into the wiper.

The controller is a four-state machine:
- `ST_RECALL` is entered from reset and lasts one cycle. It loads the wiper and moves to `ST_IDLE`.
- `ST_IDLE` accepts commands.
- `ST_STEP` accepts commands and also applies step pulses.
- `ST_STORE` holds busy until the write timer expires and then returns to `ST_IDLE`.

Transitions:
- A bank-0 step command moves to `ST_STEP` from `ST_IDLE` or `ST_STEP`.
- An unprotected store moves to `ST_STORE`.
- Any other command that is carried out returns to `ST_IDLE`.
- An ignored command leaves the state unchanged.

Top module: `wiper_bank_exec`

## Requirements
- R1: While `rst_n` is low, `wiper` is 00h and `busy` is 1. In the first cycle after release (`ST_RECALL`), `wiper` is loaded with bank 0 entry 0 and `busy` falls.
- R2: Opcode 1010 with bank 0 writes `wr_data` into the wiper. Opcode 1001 with bank 0 copies the wiper to `rd_data` one cycle later. With a nonzero bank, both opcodes are ignored.
- R3: Opcode 1100 stores `wr_data` into entry {bank_sel, reg_sel} in any bank. Opcode 1011 returns that entry on `rd_data` one cycle later.
- R4: A store holds `busy` high for exactly `WR_CYCLES` cycles, starting in the cycle after it is accepted. Every command issued during that time is ignored.
- R5: With `wp_n` low, opcodes 1100 and 1110 change no entry and do not raise `busy`. Writes to the wiper still take effect.
- R6: Opcode 1101 with bank 0 loads entry {0, reg_sel} into the wiper. With a nonzero bank it is ignored.
- R7: Opcode 1110 with bank 0 stores the wiper value into entry {0, reg_sel}, taking a write cycle as in R4. With a nonzero bank it is ignored.
- R8: Opcode 0010 with bank 0 enters step mode. There, a `step_up` pulse adds one to the wiper and a `step_dn` pulse subtracts one. Step pulses outside step mode are ignored.
- R9: Stepping saturates: up at FFh and down at 00h leave the wiper unchanged.
- R10: Opcodes not listed above change neither the wiper nor `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Command opcode |
| reg_sel | input | 2 | Entry index within a bank |
| bank_sel | input | 2 | Bank index |
| wr_data | input | 8 | Data byte for writes |
| step_up | input | 1 | Step the wiper one tap toward high |
| step_dn | input | 1 | Step the wiper one tap toward low |
| wp_n | input | 1 | Low blocks nonvolatile stores |
| rd_data | output | 8 | Result of the last read command |
| busy | output | 1 | Recall or store in progress |
| wiper | output | 8 | Current wiper position |

## Verification
The bench builds the block with `WR_CYCLES` set to 20 and keeps the default widths and counts. With that setting, the exact length of a store's busy window can be counted cycle by cycle, and a command can be placed inside that window. Because storage survives reset, the bench can store a value, reset the block and observe the recall. Saturation at both wiper ends is reached with a few step pulses after a direct wiper write.

// File: rtl/wbx_pkg.sv
package wbx_pkg;

    typedef enum logic [3:0] {
        OP_STEP    = 4'b0010,
        OP_RD_WCR  = 4'b1001,
        OP_WR_WCR  = 4'b1010,
        OP_RD_DR   = 4'b1011,
        OP_WR_DR   = 4'b1100,
        OP_DR2WCR  = 4'b1101,
        OP_WCR2DR  = 4'b1110
    } wbx_op_e;

    typedef enum logic [1:0] {
        ST_RECALL,
        ST_IDLE,
        ST_STEP,
        ST_STORE
    } wbx_state_e;

endpackage

// File: rtl/wbx_store.sv
module wbx_store #(
    parameter int DW   = 8,
    parameter int NENT = 16,
    localparam int AW  = $clog2(NENT)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] home_val
);
    logic [NENT*DW-1:0] flat;

    // one retained entry per slot; no reset, contents survive rst_n
    for (genvar i = 0; i < NENT; i++) begin : g_ent
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (we && waddr == AW'(i)) begin
                q <= wdata;
            end
        end
        assign flat[i*DW +: DW] = q;
    end

    assign rdata    = flat[int'(raddr)*DW +: DW];
    assign home_val = flat[DW-1:0];
endmodule

// File: rtl/wbx_wiper.sv
module wbx_wiper #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          up,
    input  logic          dn,
    output logic [DW-1:0] q
);
    localparam logic [DW-1:0] TOP = '1;
    localparam logic [DW-1:0] BOT = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (up && !dn && q != TOP) begin
            q <= q + 1'b1;
        end else if (dn && !up && q != BOT) begin
            q <= q - 1'b1;
        end
    end

    a_r9_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !dn && !load && q == TOP) |=> q == TOP);
    a_r9_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (dn && !up && !load && q == BOT) |=> q == BOT);
    a_r8_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !dn && !load && q != TOP) |=> q == $past(q) + 1'b1);
endmodule

// File: rtl/wbx_timer.sv
module wbx_timer #(
    parameter int CYCLES = 250000,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    logic [CW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (start) begin
            cnt    <= CW'(CYCLES - 1);
            active <= 1'b1;
        end else if (active) begin
            if (cnt == '0) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign done = active && cnt == '0;

    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);
endmodule

// File: rtl/wiper_bank_exec.sv
module wiper_bank_exec
    import wbx_pkg::*;
#(
    parameter int DW        = 8,
    parameter int NREG      = 4,
    parameter int NBANK     = 4,
    parameter int WR_CYCLES = 250000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [3:0]               cmd_op,
    input  logic [$clog2(NREG)-1:0]  reg_sel,
    input  logic [$clog2(NBANK)-1:0] bank_sel,
    input  logic [DW-1:0]            wr_data,
    input  logic                     step_up,
    input  logic                     step_dn,
    input  logic                     wp_n,
    output logic [DW-1:0]            rd_data,
    output logic                     busy,
    output logic [DW-1:0]            wiper
);
    localparam int NENT = NREG * NBANK;
    localparam int AW   = $clog2(NENT);

    wbx_state_e    state, state_n;
    logic          accept, bank0, step_en;
    logic          w_load;
    logic [DW-1:0] w_val;
    logic          st_go, t_done, mem_we;
    logic [AW-1:0] sel_addr, pend_addr;
    logic [DW-1:0] pend_data, pend_data_n, mem_rdata, home_val;
    logic          rd_ld;
    logic [DW-1:0] rd_val;

    assign sel_addr = {bank_sel, reg_sel};
    assign bank0    = (bank_sel == '0);
    assign accept   = cmd_valid && (state == ST_IDLE || state == ST_STEP);
    assign step_en  = (state == ST_STEP) && !accept;
    assign mem_we   = (state == ST_STORE) && t_done;
    assign busy     = (state == ST_RECALL) || (state == ST_STORE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RECALL;
        end else begin
            state <= state_n;
        end
    end

    // next state and command decode
    always_comb begin
        state_n     = state;
        w_load      = 1'b0;
        w_val       = wr_data;
        st_go       = 1'b0;
        pend_data_n = wr_data;
        rd_ld       = 1'b0;
        rd_val      = wiper;
        unique case (state)
            ST_RECALL: begin
                w_load  = 1'b1;
                w_val   = home_val;
                state_n = ST_IDLE;
            end
            ST_STORE: begin
                if (t_done) state_n = ST_IDLE;
            end
            ST_IDLE, ST_STEP: begin
                if (accept) begin
                    case (cmd_op)
                        OP_RD_WCR: if (bank0) begin
                            rd_ld = 1'b1; rd_val = wiper; state_n = ST_IDLE;
                        end
                        OP_WR_WCR: if (bank0) begin
                            w_load = 1'b1; w_val = wr_data; state_n = ST_IDLE;
                        end
                        OP_RD_DR: begin
                            rd_ld = 1'b1; rd_val = mem_rdata; state_n = ST_IDLE;
                        end
                        OP_WR_DR: begin
                            state_n = ST_IDLE;
                            if (wp_n) begin
                                st_go = 1'b1; pend_data_n = wr_data; state_n = ST_STORE;
                            end
                        end
                        OP_DR2WCR: if (bank0) begin
                            w_load = 1'b1; w_val = mem_rdata; state_n = ST_IDLE;
                        end
                        OP_WCR2DR: if (bank0) begin
                            state_n = ST_IDLE;
                            if (wp_n) begin
                                st_go = 1'b1; pend_data_n = wiper; state_n = ST_STORE;
                            end
                        end
                        OP_STEP: if (bank0) state_n = ST_STEP;
                        default: ;
                    endcase
                end
            end
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data   <= '0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            if (rd_ld) rd_data <= rd_val;
            if (st_go) begin
                pend_addr <= sel_addr;
                pend_data <= pend_data_n;
            end
        end
    end

    wbx_store #(.DW(DW), .NENT(NENT)) u_store (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (pend_addr),
        .wdata   (pend_data),
        .raddr   (sel_addr),
        .rdata   (mem_rdata),
        .home_val(home_val)
    );

    wbx_wiper #(.DW(DW)) u_wiper (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (w_load),
        .load_val(w_val),
        .up      (step_up && step_en),
        .dn      (step_dn && step_en),
        .q       (wiper)
    );

    wbx_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(st_go),
        .done (t_done)
    );

    a_r1_recall: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RECALL |=> wiper == $past(home_val));
    a_r4_store_holds_wiper: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_STORE |=> $stable(wiper));
    a_r5_protect_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wp_n && (cmd_op == OP_WR_DR || cmd_op == OP_WCR2DR)) |=> !busy);
endmodule

// File: tb/test_wiper_bank_exec.sv
module test_wiper_bank_exec;
    localparam int WRC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [1:0] reg_sel = '0, bank_sel = '0;
    logic [7:0] wr_data = '0;
    logic       step_up = 1'b0, step_dn = 1'b0, wp_n = 1'b1;
    logic [7:0] rd_data, wiper;
    logic       busy;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wiper_bank_exec #(.WR_CYCLES(WRC)) i_wiper_bank_exec (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .reg_sel(reg_sel), .bank_sel(bank_sel), .wr_data(wr_data),
        .step_up(step_up), .step_dn(step_dn), .wp_n(wp_n),
        .rd_data(rd_data), .busy(busy), .wiper(wiper));

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmd(logic [3:0] op, logic [1:0] b, logic [1:0] r, logic [7:0] d);
        cmd_op = op; bank_sel = b; reg_sel = r; wr_data = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic pulse(bit up);
        if (up) step_up = 1'b1; else step_dn = 1'b1;
        @(negedge clk);
        step_up = 1'b0; step_dn = 1'b0;
    endtask

    task automatic read_dr(logic [1:0] b, logic [1:0] r, output logic [7:0] v);
        cmd(4'b1011, b, r, 8'h00);
        v = rd_data;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset wiper", wiper, 8'h00);
        check("R1 reset busy", busy, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after recall", busy, 0);
    endtask

    task automatic t_wcr();
        cmd(4'b1010, 2'd0, 2'd0, 8'h5A);
        check("R2 wiper write", wiper, 8'h5A);
        cmd(4'b1001, 2'd0, 2'd0, 8'h00);
        check("R2 wiper read", rd_data, 8'h5A);
        cmd(4'b1010, 2'd1, 2'd0, 8'h33);
        check("R2 nonzero bank write ignored", wiper, 8'h5A);
    endtask

    task automatic t_store();
        logic [7:0] v;
        int cnt = 0;
        cmd(4'b1100, 2'd2, 2'd3, 8'hC3);
        while (busy) begin cnt++; @(negedge clk); end
        check("R4 busy length", cnt, WRC);
        read_dr(2'd2, 2'd3, v);
        check("R3 bank2 entry3 readback", v, 8'hC3);
        cmd(4'b1100, 2'd0, 2'd0, 8'h11); wait_idle();
        cmd(4'b1100, 2'd0, 2'd1, 8'h77); wait_idle();
        cmd(4'b1100, 2'd3, 2'd2, 8'h0F); wait_idle();
        read_dr(2'd0, 2'd1, v);
        check("R3 bank0 entry1 readback", v, 8'h77);
        // command during busy
        cmd(4'b1100, 2'd1, 2'd1, 8'hAB);
        cmd(4'b1010, 2'd0, 2'd0, 8'h99);
        check("R4 wiper write ignored while busy", wiper, 8'h5A);
        wait_idle();
        check("R4 wiper still unchanged", wiper, 8'h5A);
    endtask

    task automatic t_protect();
        logic [7:0] v;
        wp_n = 1'b0;
        cmd(4'b1100, 2'd0, 2'd1, 8'hEE);
        check("R5 no busy when protected", busy, 0);
        cmd(4'b1010, 2'd0, 2'd0, 8'h21);
        check("R5 wiper write under protect", wiper, 8'h21);
        cmd(4'b1110, 2'd0, 2'd1, 8'h00);
        check("R5 no busy on protected transfer", busy, 0);
        read_dr(2'd0, 2'd1, v);
        check("R5 entry unchanged", v, 8'h77);
        wp_n = 1'b1;
    endtask

    task automatic t_transfers();
        logic [7:0] v;
        cmd(4'b1101, 2'd0, 2'd1, 8'h00);
        check("R6 entry to wiper", wiper, 8'h77);
        cmd(4'b1101, 2'd1, 2'd1, 8'h00);
        check("R6 nonzero bank ignored", wiper, 8'h77);
        cmd(4'b1010, 2'd0, 2'd0, 8'h42);
        cmd(4'b1110, 2'd0, 2'd2, 8'h00);
        check("R7 transfer busy", busy, 1);
        wait_idle();
        read_dr(2'd0, 2'd2, v);
        check("R7 wiper stored", v, 8'h42);
        cmd(4'b1110, 2'd3, 2'd2, 8'h00);
        check("R7 nonzero bank no busy", busy, 0);
        read_dr(2'd3, 2'd2, v);
        check("R7 bank3 entry unchanged", v, 8'h0F);
    endtask

    task automatic t_step();
        pulse(1);
        check("R8 step outside mode ignored", wiper, 8'h42);
        cmd(4'b0010, 2'd0, 2'd0, 8'h00);
        pulse(1); pulse(1); pulse(1);
        check("R8 three up steps", wiper, 8'h45);
        pulse(0);
        check("R8 one down step", wiper, 8'h44);
        cmd(4'b1010, 2'd0, 2'd0, 8'hFE);
        pulse(1);
        check("R8 step after leaving mode ignored", wiper, 8'hFE);
        cmd(4'b0010, 2'd0, 2'd0, 8'h00);
        pulse(1); pulse(1); pulse(1);
        check("R9 saturate high", wiper, 8'hFF);
        cmd(4'b1010, 2'd0, 2'd0, 8'h01);
        cmd(4'b0010, 2'd0, 2'd0, 8'h00);
        pulse(0); pulse(0); pulse(0);
        check("R9 saturate low", wiper, 8'h00);
    endtask

    task automatic t_unknown();
        cmd(4'b1010, 2'd0, 2'd0, 8'h6C);
        cmd(4'b1001, 2'd0, 2'd0, 8'h00);
        cmd(4'b0111, 2'd0, 2'd0, 8'hFF);
        cmd(4'b0000, 2'd0, 2'd0, 8'hFF);
        check("R10 wiper unchanged", wiper, 8'h6C);
        check("R10 rd_data unchanged", rd_data, 8'h6C);
        check("R10 no busy", busy, 0);
    endtask

    task automatic t_recall();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 recall of bank0 entry0", wiper, 8'h11);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_wcr();
        t_store();
        t_protect();
        t_transfers();
        t_step();
        t_unknown();
        t_recall();
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule